// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces refresh requests for a DRAM controller. Software programs one 24-bit control word over a plain write/read port. The word selects whether the cycle clock is first divided by 64, sets an 8-bit rate value, enables periodic operation, and can force a single refresh by hand. From these settings the block raises a refresh request and holds it until the controller reports completion on a done input.

Timing works as follows. A tick arrives every cycle, or every 64th cycle when the prescaler is selected. A refresh falls due once every (rate + 1) ticks. Requests that fall due while one is still outstanding are folded into it, so a single completion answers all of them. The manual trigger bit clears itself on that same completion. The other fields of the word are storage for neighbouring logic and are kept as written.

Top module: `refresh_timer`

## Requirements
- R1: After a synchronous reset the control word reads 0x000000 and `refresh_req` is low.
- R2: Writes are stored and read back on `rd_data` in the cycle after the write, except bits 10 and 7..4, which always read 0. Writing 0xFFFFFF reads back as 0xFFFB0F.
- R3: With bit 23 = 0 and enable (bit 13) = 1, `refresh_req` rises (rate+1) cycles after the enabling write. The rate is bits 22..15, values 0..255.
- R4: With bit 23 = 1, the period is 64*(rate+1) cycles.
- R5: While bit 13 = 0 no periodic request is made. Each enable starts a full fresh period.
- R6: A pending request stays high until `refresh_done` is sampled high. Further periods that expire meanwhile are merged into it and are not served again.
- R7: Writing 1 to bit 14 raises `refresh_req` one cycle later. Bit 14 reads 1 until the completing `refresh_done`, which clears both the bit and the request.
- R8: A software trigger and a periodic expiry that are pending together are served by one completion.
- R9: `refresh_done` while no request is pending has no effect on `refresh_req` or on the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 24 | Value to write |
| rd_data | output | 24 | Current control word |
| refresh_req | output | 1 | Refresh request to the controller, held until done |
| refresh_done | input | 1 | Controller reports the refresh finished |

## Verification
The bench measures the exact cycle distance from the enabling write to the request at both extremes of the rate field, with and without the prescaler. An off-by-one counter, or a prescaler that drops or adds a tick, shows up there as a wrong count. It holds a request across several expiries and then checks that a single done leaves the line low until the next full period. A design that queued expiries would raise the request again at once. It also lets a manual trigger and an expiry overlap before completing both with one done, and pulses done while idle. A wrongly wired clear would leave bit 14 set, or would change the word.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int CTRL_W   = 24;
  localparam int BIT_PRE  = 23;
  localparam int RATE_LSB = 15;
  localparam int RATE_W   = 8;
  localparam int BIT_SW   = 14;
  localparam int BIT_EN   = 13;
  localparam logic [CTRL_W-1:0] RSV_MASK = 24'h0004F0;
endpackage

// File: rtl/rt_ctrl_reg.sv
module rt_ctrl_reg
  import rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              sw_clr,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (sw_clr) ctrl_q[BIT_SW] <= 1'b0;
      if (wr_en) ctrl_q <= wr_data & ~RSV_MASK;
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & RSV_MASK) == '0);

  assert_sw_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[BIT_SW] && sw_clr && !wr_en) |=> !ctrl_q[BIT_SW]);
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int PRE_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic div_sel,
  output logic tick
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk) begin
        if (rst || !run)      pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                  pcnt <= pcnt + 1'b1;
      end

      assign tick = run && (!div_sel || pcnt == LAST);

      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (run && div_sel && tick && $stable(div_sel)) |=> !tick);
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = tick && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
  end

  assert_stopped_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/rt_req.sv
module rt_req (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic sw,
  input  logic done,
  output logic req_q,
  output logic done_ok
);
  logic set_now;

  assign done_ok = done && req_q;
  assign set_now = hit || (sw && !done_ok);

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= set_now || (req_q && !done_ok);
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_q && !done) |=> req_q);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (req_q && done && !hit) |=> !req_q);

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!req_q && !hit && !sw) |=> !req_q);
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rt_pkg::*;
#(
  parameter int PRE_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              refresh_req,
  input  logic              refresh_done
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              tick, hit, done_ok;

  rt_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sw_clr(done_ok), .ctrl_q(ctrl_q)
  );

  rt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl_q[BIT_EN]),
    .div_sel(ctrl_q[BIT_PRE]), .tick(tick)
  );

  rt_counter #(.W(RATE_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_q[BIT_EN]), .tick(tick),
    .limit(ctrl_q[RATE_LSB +: RATE_W]), .hit(hit)
  );

  rt_req u_req (
    .clk(clk), .rst(rst), .hit(hit), .sw(ctrl_q[BIT_SW]),
    .done(refresh_done), .req_q(refresh_req), .done_ok(done_ok)
  );

  assign rd_data = ctrl_q;

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[BIT_EN] && !ctrl_q[BIT_SW] && !refresh_req) |=> !refresh_req);

  assert_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (!refresh_req && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/refresh_timer_tb.sv
module refresh_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        refresh_req;
  logic        refresh_done = 1'b0;

  int checks = 0;
  int errors = 0;

  localparam int NV = 6;
  localparam logic [23:0] CFG [0:NV-1] =
    '{24'h002000, 24'h02A000, 24'h7FA000, 24'h802000, 24'h812000, 24'hFFA000};
  localparam int CYC [0:NV-1] = '{1, 6, 256, 64, 192, 16384};

  refresh_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .refresh_req(refresh_req), .refresh_done(refresh_done)
  );

  always #2 clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse;
    refresh_done = 1'b1;
    step(1);
    refresh_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R0 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 req", refresh_req, 0);

    // R2 readback with reserved bits
    wr(24'hFFFFFF);
    chk("R2 all-ones readback", rd_data, 24'hFFFB0F);
    wr(24'h000000);
    done_pulse();
    chk("R2 cleared", rd_data, 0);
    chk("R2 req cleared", refresh_req, 0);

    // R3 / R4 period table
    for (int v = 0; v < NV; v++) begin
      wr(CFG[v]);
      chk(CFG[v][23] ? "R4 readback" : "R3 readback", rd_data, CFG[v]);
      n = 0;
      while (!refresh_req && n < 20000) begin
        step(1);
        n++;
      end
      chk(CFG[v][23] ? "R4 period" : "R3 period", n, CYC[v]);
      wr(24'h000000);
      done_pulse();
      chk("R6 cleared after done", refresh_req, 0);
    end

    // R5 disabled: no request
    wr(24'h002000 | (24'd3 << 15));
    step(2);
    wr(24'h000000 | (24'd3 << 15));
    step(20);
    chk("R5 disabled no request", refresh_req, 0);
    wr(24'h002000 | (24'd3 << 15));
    n = 0;
    while (!refresh_req && n < 100) begin
      step(1);
      n++;
    end
    chk("R5 full period after re-enable", n, 4);
    wr(24'h000000);
    done_pulse();

    // R6 merge: rate 3, expiries after edges 4, 8, 12
    wr(24'h002000 | (24'd3 << 15));  // edge E0
    step(3);                         // after E3
    chk("R6 rise edge", refresh_req, 0);
    step(1);                         // after E4
    chk("R6 raised", refresh_req, 1);
    step(4);                         // after E8, second expiry merged
    chk("R6 held", refresh_req, 1);
    done_pulse();                    // after E9
    chk("R6 done clears", refresh_req, 0);
    step(2);                         // after E11
    chk("R6 no duplicate", refresh_req, 0);
    step(1);                         // after E12
    chk("R6 next period", refresh_req, 1);
    wr(24'h000000);
    done_pulse();

    // R7 software trigger
    wr(24'h004000);
    chk("R7 bit14 reads 1", rd_data, 24'h004000);
    chk("R7 req not yet", refresh_req, 0);
    step(1);
    chk("R7 req raised", refresh_req, 1);
    step(3);
    chk("R7 held", rd_data[14], 1);
    done_pulse();
    chk("R7 bit cleared", rd_data, 0);
    chk("R7 req cleared", refresh_req, 0);
    step(3);
    chk("R7 stays low", refresh_req, 0);

    // R8 trigger plus expiry with one done
    wr(24'h006000 | (24'd3 << 15));  // E0
    step(4);                         // after E4, expiry merged with trigger
    chk("R8 req", refresh_req, 1);
    done_pulse();                    // after E5
    chk("R8 req cleared", refresh_req, 0);
    chk("R8 bit14 cleared", rd_data[14], 0);
    step(2);                         // after E7
    chk("R8 served once", refresh_req, 0);
    wr(24'h000000);
    done_pulse();

    // R9 done while idle
    wr(24'h8A0B05);
    done_pulse();
    chk("R9 word unchanged", rd_data, 24'h8A0B05);
    chk("R9 req low", refresh_req, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule